// File: doc/BRIEF.md
# Dual-channel baud clock divider

The block turns a CPU clock into two square-wave clocks for a serial controller. Channel 0 makes the transmit clock and channel 1 makes the receive clock. A free-running prescaler first halves the CPU clock to form the timer count rate. Each channel then divides that rate by a 16-bit divisor, so that its output runs at sixteen times the chosen baud rate. Software uses a byte-wide write bus with a two-bit offset. It first writes a control word that picks a channel. It then writes that channel's divisor as two bytes, low byte first.

A divisor takes effect only when its high byte lands. Until then the channel keeps its old waveform. When the high byte lands, the channel restarts at the start of a high phase. For odd divisors the high phase is the longer one. A divisor of 0 is counted as 65536. Control words that address a channel the block does not have, or that ask for a load sequence, mode or number format other than the one built, are dropped without effect. As an example, a 4 MHz CPU with divisor 417 gives 300 baud, because divisor = fCPU / (32 × baud).

Top module: `baud_timer`

## Requirements
- R1: A write at offset 3 is a control word. Bits [7:6] select the channel (00 selects channel 0, 01 selects channel 1). Bits [5:4] must be 11 (low byte then high byte). Bits [3:1] must be 011 (square wave). Bit 0 must be 0 (binary). So 0x36 arms channel 0 and 0x76 arms channel 1.
- R2: A control word with bit 7 set changes neither channel's byte sequence nor its divisor.
- R3: A control word at offset 3 whose load bits, mode bits or format bit differ from R1 is ignored. It does not restart the byte sequence of the channel it names.
- R4: After a control word, the first write to the channel's counter port (offset 0 for channel 0, offset 1 for channel 1) is the divisor's low byte. The second write is its high byte and commits the divisor. Further writes without a new control word keep alternating low then high.
- R5: Until the high byte is written, a channel keeps running with its previous divisor.
- R6: In the clock cycle after the high-byte write, the channel's output is high and a new high phase has begun.
- R7: With divisor N and prescale P (default 2), the output stays high for ceil(N/2)·P CPU clock cycles and low for floor(N/2)·P cycles, repeating.
- R8: A divisor of 1 holds the output constantly high.
- R9: After reset both outputs are high and stay high until a divisor is committed. Counter-port writes made before any control word for that channel are ignored.
- R10: Loading one channel leaves the other channel's waveform unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; bus writes and counting run on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register offset: 0 channel 0 counter, 1 channel 1 counter, 3 control |
| bus_wdata | input | 8 | Write data byte |
| tx_clk_o | output | 1 | Channel 0 square-wave output (transmit clock) |
| rx_clk_o | output | 1 | Channel 1 square-wave output (receive clock) |

## Verification
The bench checks the byte sequence in three ways. It writes only the low byte and checks that the old waveform goes on; a design that committed early would change the rate half-loaded. It puts a rejected control word (bit 7 set, or a wrong mode or format field) between the low and high bytes; a design that decoded it would restart the sequence and never commit. It loads while the output is low and checks that the output goes high in the next cycle; a design that waited for the current phase to end would fail this. Odd divisors check that the high phase is the longer one. A divisor of 1 must never drop the output. While one channel is reloaded, the bench times the other channel to catch shared state.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int BYTE_W   = 8;
  localparam int DIV_W    = 2 * BYTE_W;
  localparam int NUM_CH   = 2;
  localparam int ADDR_W   = 2;
  localparam int CTRL_OFS = 3;

  typedef struct packed {
    logic [1:0] sel;
    logic [1:0] rl;
    logic [2:0] mode;
    logic       bcd;
  } ctrl_word_t;

  localparam logic [1:0] RL_LO_HI  = 2'b11;
  localparam logic [2:0] MODE_SQW  = 3'b011;
endpackage

// File: rtl/bt_prescale.sv
module bt_prescale #(
  parameter int PRESCALE = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE > 1) begin : g_div
      logic [CW-1:0] cnt_q, cnt_d;

      always_comb begin
        if (cnt_q == CW'(PRESCALE - 1)) cnt_d = '0;
        else                             cnt_d = cnt_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      assign tick_o = (cnt_q == CW'(PRESCALE - 1));

      // R7
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end else begin : g_pass
      assign tick_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/bt_ctrl_dec.sv
module bt_ctrl_dec
  import bt_pkg::*;
(
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [NUM_CH-1:0] arm_o,
  output logic [NUM_CH-1:0] port_wr_o
);
  ctrl_word_t cw;
  logic       ctrl_wr;
  logic       fmt_ok;

  always_comb begin
    cw      = ctrl_word_t'(bus_wdata);
    ctrl_wr = bus_we && (bus_addr == ADDR_W'(CTRL_OFS));
    fmt_ok  = (cw.rl == RL_LO_HI) && (cw.mode == MODE_SQW) && !cw.bcd;
  end

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      assign arm_o[i]     = ctrl_wr && fmt_ok && (cw.sel == 2'(i));
      assign port_wr_o[i] = bus_we && (bus_addr == ADDR_W'(i));
    end
  endgenerate
endmodule

// File: rtl/bt_loader.sv
module bt_loader
  import bt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic              load_o,
  output logic [DIV_W-1:0]  div_o
);
  logic              armed_q, armed_d;
  logic              hi_q, hi_d;
  logic [BYTE_W-1:0] lo_q, lo_d;
  logic              lo_en;

  always_comb begin
    armed_d = armed_q;
    hi_d    = hi_q;
    lo_en   = 1'b0;
    lo_d    = data_i;
    if (arm_i) begin
      armed_d = 1'b1;
      hi_d    = 1'b0;
    end else if (wr_i && armed_q) begin
      if (!hi_q) lo_en = 1'b1;
      hi_d = !hi_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      hi_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      hi_q    <= hi_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end

  assign load_o = wr_i && armed_q && hi_q;
  assign div_o  = {data_i, lo_q};

  // R1
  arm_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i |=> (armed_q && !hi_q));
  // R4
  low_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && armed_q && !hi_q && !arm_i) |=> hi_q);
  // R9
  unarmed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !hi_q);
endmodule

// File: rtl/bt_channel.sv
module bt_channel
  import bt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             out_o
);
  logic             run_q, run_d;
  logic             out_q, out_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DIV_W-1:0] rem_q, rem_d;

  function automatic logic [DIV_W:0] full_len(input logic [DIV_W-1:0] d);
    full_len = (d == '0) ? {1'b1, {DIV_W{1'b0}}} : {1'b0, d};
  endfunction

  function automatic logic [DIV_W-1:0] hi_len(input logic [DIV_W-1:0] d);
    logic [DIV_W:0] f;
    f      = full_len(d);
    hi_len = DIV_W'(f - (f >> 1));
  endfunction

  function automatic logic [DIV_W-1:0] lo_len(input logic [DIV_W-1:0] d);
    logic [DIV_W:0] f;
    f      = full_len(d);
    lo_len = DIV_W'(f >> 1);
  endfunction

  always_comb begin
    run_d = run_q;
    out_d = out_q;
    div_d = div_q;
    rem_d = rem_q;
    if (load_i) begin
      run_d = 1'b1;
      out_d = 1'b1;
      div_d = div_i;
      rem_d = hi_len(div_i);
    end else if (run_q && tick_i) begin
      if (rem_q == DIV_W'(1)) begin
        if (out_q && (lo_len(div_q) != '0)) begin
          out_d = 1'b0;
          rem_d = lo_len(div_q);
        end else begin
          out_d = 1'b1;
          rem_d = hi_len(div_q);
        end
      end else begin
        rem_d = rem_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      out_q <= 1'b1;
      div_q <= '0;
      rem_q <= '0;
    end else begin
      run_q <= run_d;
      out_q <= out_d;
      div_q <= div_d;
      rem_q <= rem_d;
    end
  end

  assign out_o = out_q;

  // R7
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !tick_i) |=> $stable(out_q));
  // R7
  rem_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (rem_q != '0));
  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> out_q);
  // R6
  load_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (out_q && run_q));
  // R8
  unit_div_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && div_q == DIV_W'(1)) |-> out_q);
endmodule

// File: rtl/baud_timer.sv
module baud_timer
  import bt_pkg::*;
#(
  parameter int PRESCALE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic              tx_clk_o,
  output logic              rx_clk_o
);
  logic              tick;
  logic [NUM_CH-1:0] arm;
  logic [NUM_CH-1:0] port_wr;
  logic [NUM_CH-1:0] load;
  logic [NUM_CH-1:0] ch_out;
  logic [DIV_W-1:0]  ch_div [NUM_CH];

  bt_prescale #(.PRESCALE(PRESCALE)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  bt_ctrl_dec u_dec (
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .arm_o     (arm),
    .port_wr_o (port_wr)
  );

  generate
    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      bt_loader u_ld (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm_i  (arm[i]),
        .wr_i   (port_wr[i]),
        .data_i (bus_wdata),
        .load_o (load[i]),
        .div_o  (ch_div[i])
      );

      bt_channel u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .load_i (load[i]),
        .div_i  (ch_div[i]),
        .out_o  (ch_out[i])
      );
    end
  endgenerate

  assign tx_clk_o = ch_out[0];
  assign rx_clk_o = ch_out[1];

  // R2
  no_sc1_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(CTRL_OFS) && bus_wdata[7]) |-> (arm == '0));
  // R10
  one_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load));
endmodule

// File: tb/test_baud_timer.sv
module test_baud_timer;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  typedef struct packed {
    logic        ch;
    logic [15:0] div;
    logic [31:0] hi;
    logic [31:0] lo;
  } vec_t;

  localparam vec_t VEC [0:4] = '{
    '{1'b0, 16'd417, 32'd418, 32'd416},
    '{1'b1, 16'd10,  32'd10,  32'd10},
    '{1'b0, 16'd7,   32'd8,   32'd6},
    '{1'b1, 16'd2,   32'd2,   32'd2},
    '{1'b0, 16'd3,   32'd4,   32'd2}
  };

  logic       clk;
  logic       rst_n;
  logic       bus_we;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       tx_clk_o;
  logic       rx_clk_o;

  int checks;
  int errors;
  bit done;

  baud_timer i_baud_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .tx_clk_o  (tx_clk_o),
    .rx_clk_o  (rx_clk_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  function automatic logic sample(input logic ch);
    return ch ? rx_clk_o : tx_clk_o;
  endfunction

  task automatic wait_level(input logic ch, input logic lvl);
    for (int k = 0; k < 70000 && sample(ch) != lvl; k++) @(negedge clk);
  endtask

  task automatic measure(input logic ch, output int hi, output int lo);
    hi = 0;
    lo = 0;
    wait_level(ch, 1'b0);
    wait_level(ch, 1'b1);
    while (sample(ch) == 1'b1 && hi < 70000) begin
      hi++;
      @(negedge clk);
    end
    while (sample(ch) == 1'b0 && lo < 70000) begin
      lo++;
      @(negedge clk);
    end
  endtask

  task automatic load(input logic ch, input logic [15:0] d);
    wr(2'd3, ch ? 8'h76 : 8'h36);
    wr({1'b0, ch}, d[7:0]);
    wr({1'b0, ch}, d[15:8]);
  endtask

  task automatic expect_wave(input string tag, input logic ch, input int ehi, input int elo);
    int h, l;
    measure(ch, h, l);
    check({tag, " high"}, h, ehi);
    check({tag, " low"}, l, elo);
  endtask

  task automatic expect_steady_high(input string tag, input logic ch, input int n);
    int lows;
    lows = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (sample(ch) == 1'b0) lows++;
    end
    check(tag, lows, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    finish_run();
  end

  initial begin
    checks    = 0;
    errors    = 0;
    done      = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = 2'd0;
    bus_wdata = 8'h00;
    rst_n     = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state and counter writes with no control word
    check("R9 reset tx", tx_clk_o, 1);
    check("R9 reset rx", rx_clk_o, 1);
    wr(2'd1, 8'd5);
    wr(2'd1, 8'd0);
    expect_steady_high("R9 rx idle", 1'b1, 100);
    expect_steady_high("R9 tx idle", 1'b0, 20);

    // R1 R7: table of loads and expected waveforms
    foreach (VEC[i]) begin
      load(VEC[i].ch, VEC[i].div);
      check($sformatf("R6 vec%0d high after load", i), sample(VEC[i].ch), 1);
      expect_wave($sformatf("R7 vec%0d", i), VEC[i].ch, int'(VEC[i].hi), int'(VEC[i].lo));
    end

    // R5: low byte alone keeps old divisor 3
    wr(2'd3, 8'h36);
    wr(2'd0, 8'd10);
    expect_wave("R5 ch0 old div", 1'b0, 4, 2);
    // R4: high byte commits divisor 10
    wr(2'd0, 8'd0);
    expect_wave("R4 ch0 div10", 1'b0, 10, 10);
    // R4: a second pair without a control word
    wr(2'd0, 8'd6);
    wr(2'd0, 8'd0);
    expect_wave("R4 ch0 second pair", 1'b0, 6, 6);
    // R10: channel 1 still at divisor 2
    expect_wave("R10 ch1 undisturbed", 1'b1, 2, 2);

    // R2: control word with bit 7 set between bytes
    wr(2'd3, 8'h36);
    wr(2'd0, 8'd4);
    wr(2'd3, 8'hB6);
    wr(2'd0, 8'd0);
    expect_wave("R2 sc1 ignored ch0", 1'b0, 4, 4);
    expect_wave("R2 sc1 ignored ch1", 1'b1, 2, 2);

    // R3: wrong mode between bytes
    wr(2'd3, 8'h36);
    wr(2'd0, 8'd8);
    wr(2'd3, 8'h34);
    wr(2'd0, 8'd0);
    expect_wave("R3 mode ignored", 1'b0, 8, 8);
    // R3: BCD flag between bytes
    wr(2'd3, 8'h36);
    wr(2'd0, 8'd12);
    wr(2'd3, 8'h37);
    wr(2'd0, 8'd0);
    expect_wave("R3 bcd ignored", 1'b0, 12, 12);

    // R6: load while output is low restarts high at once
    load(1'b0, 16'd10);
    wait_level(1'b0, 1'b1);
    wait_level(1'b0, 1'b0);
    wr(2'd3, 8'h36);
    wr(2'd0, 8'd20);
    wait_level(1'b0, 1'b1);
    wait_level(1'b0, 1'b0);
    wr(2'd0, 8'd0);
    check("R6 restart high", tx_clk_o, 1);
    expect_wave("R6 ch0 div20", 1'b0, 20, 20);

    // R8: divisor 1 holds high
    load(1'b1, 16'd1);
    expect_steady_high("R8 div1 steady", 1'b1, 300);
    expect_wave("R10 ch0 after ch1 load", 1'b0, 20, 20);

    finish_run();
  end
endmodule